// File: doc/BRIEF.md
# Five-Port Mesh Router Switching Core

This block is the switching heart of one router in a two-dimensional mesh. Five ports face north, east, south, west and the local core. Each port brings a head flit from its own input FIFO. Each output reports the state of the buffer it feeds downstream. The switch serves one input stream at a time. It chooses that stream with a round-robin arbiter that works per packet. It steers the flits to one output by comparing coordinates, X first and then Y, and it strobes the input FIFO so that FIFO drops each flit the switch accepted.

Every 20-bit flit carries its destination, so each hop decides the route from the flit itself. A packet is a fixed number of flits (`PKT_FLITS`). The grant stays with one input until that many flits have passed. The downstream state works as a three-level flow control (go, one slot left, stop). An input whose packet was held up by a full downstream buffer is moved behind the other inputs in the next arbitration.

Top module: `mesh_xy_switch`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after reset with no requests, every `out_vld` and `in_pop` bit is 0 and every `out_flit` lane is zero.
- R2: Port index order is 0 north, 1 east, 2 south, 3 west, 4 local. The flit is laid out as destination X in bits 19:17, destination Y in 16:14, source coordinates in 13:8 and payload in 7:0. If destination X is greater than `MY_X` the flit goes east, and if it is smaller the flit goes west, whatever the Y value.
- R3: When destination X equals `MY_X`, the flit goes north if destination Y is greater than `MY_Y` and south if it is smaller.
- R4: When both coordinates match the router's own, the flit goes to the local output.
- R5: In any cycle at most one `in_pop` bit is set. Exactly one output carries the popped flit, unchanged, in its lane, and every other lane is zero.
- R6: An idle switch spends one cycle arbitrating, with no output active. It then holds the grant on that input for exactly `PKT_FLITS` forwarded flits.
- R7: After a packet ends, the round-robin search starts at the input after the one just served, in index order and wrapping from 4 to 0.
- R8: Downstream state is two bits per output (0 go, 1 one slot left, 2 or 3 stop). No flit is forwarded to an output in stop, and the grant is kept during the stall.
- R9: While an output stays in the one-slot state, exactly one flit is forwarded to it. After that, forwarding resumes only once the state has returned to go.
- R10: An input that was stalled by a stop during its grant loses to any other requesting input in the next arbitration, whatever the pointer says. Its normal rank is restored once it has been granted.
- R11: If the granted input's `in_vld` drops in the middle of a packet, nothing is forwarded and the grant stays on that input. Other requesting inputs are not served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 5 | Head flit present, per input port |
| in_flit | input | 100 | Head flits, 20 bits per port, port 0 in the low lane |
| ds_state | input | 10 | Downstream buffer state, 2 bits per output |
| in_pop | output | 5 | Strobe that dequeues the head flit of an input FIFO |
| out_vld | output | 5 | Flit valid, per output port |
| out_flit | output | 100 | Output flits, 20 bits per port, zero when idle |

## Verification
The bench sets up destinations where X and Y point in conflicting directions. A switch that resolved Y first would send those flits north or south instead of east or west. Sequences of several requesters pin down the pointer advance. Demotion is checked in a case where the pointer would favour the stalled input: a switch without demotion grants that input first, and a switch that never clears demotion keeps skipping it on the next round. Stalls from stop, from the one-slot state and from a source bubble in mid-packet show whether a faulty switch leaks extra flits, drops the grant or lets another input slip in.

// File: rtl/mesh_sw_pkg.sv
package mesh_sw_pkg;
   localparam int NDIR = 5;
   localparam int D_N = 0;
   localparam int D_E = 1;
   localparam int D_S = 2;
   localparam int D_W = 3;
   localparam int D_L = 4;

   typedef enum logic [1:0] {
      LNK_GO   = 2'd0,
      LNK_ONE  = 2'd1,
      LNK_HALT = 2'd2,
      LNK_RSV  = 2'd3
   } link_st_e;
endpackage

// File: rtl/xy_route.sv
module xy_route
   import mesh_sw_pkg::*;
#(
   parameter int COORD_W = 3,
   parameter int MY_X    = 3,
   parameter int MY_Y    = 3
) (
   input  logic [2*COORD_W-1:0] dst_xy,
   output logic [NDIR-1:0]      dir_oh
);
   localparam logic [COORD_W-1:0] OWN_X = COORD_W'(MY_X);
   localparam logic [COORD_W-1:0] OWN_Y = COORD_W'(MY_Y);

   logic [COORD_W-1:0] dx, dy;
   assign dx = dst_xy[2*COORD_W-1 -: COORD_W];
   assign dy = dst_xy[COORD_W-1:0];

   always_comb begin
      dir_oh = '0;
      if (dx > OWN_X)      dir_oh[D_E] = 1'b1;
      else if (dx < OWN_X) dir_oh[D_W] = 1'b1;
      else if (dy > OWN_Y) dir_oh[D_N] = 1'b1;
      else if (dy < OWN_Y) dir_oh[D_S] = 1'b1;
      else                 dir_oh[D_L] = 1'b1;
   end
endmodule

// File: rtl/rr_pick.sv
module rr_pick #(
   parameter int N = 5,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   input  logic [IW-1:0] ptr,
   output logic          any,
   output logic [IW-1:0] idx
);
   always_comb begin
      any = 1'b0;
      idx = '0;
      for (int k = N - 1; k >= 0; k--) begin
         if (req[(int'(ptr) + k) % N]) begin
            any = 1'b1;
            idx = IW'((int'(ptr) + k) % N);
         end
      end
   end
endmodule

// File: rtl/mesh_xy_switch.sv
module mesh_xy_switch
   import mesh_sw_pkg::*;
#(
   parameter int FLIT_W    = 20,
   parameter int COORD_W   = 3,
   parameter int PKT_FLITS = 4,
   parameter int MY_X      = 3,
   parameter int MY_Y      = 3
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NDIR-1:0]        in_vld,
   input  logic [NDIR*FLIT_W-1:0] in_flit,
   input  logic [2*NDIR-1:0]      ds_state,
   output logic [NDIR-1:0]        in_pop,
   output logic [NDIR-1:0]        out_vld,
   output logic [NDIR*FLIT_W-1:0] out_flit
);
   localparam int IW    = $clog2(NDIR);
   localparam int CNT_W = (PKT_FLITS > 1) ? $clog2(PKT_FLITS) : 1;
   localparam int MAXC  = (1 << COORD_W) - 1;

   if (FLIT_W < 4 * COORD_W + 1) begin : g_bad_flit
      $error("flit too narrow for header");
   end
   if (PKT_FLITS < 1) begin : g_bad_pkt
      $error("packet length must be positive");
   end
   if (MY_X >= MAXC || MY_Y >= MAXC || MY_X < 0 || MY_Y < 0) begin : g_bad_xy
      $error("router coordinate out of range");
   end

   logic               busy;
   logic [IW-1:0]      owner, rr_ptr;
   logic [CNT_W-1:0]   cnt;
   logic [NDIR-1:0]    lowp, sent_used;

   logic [FLIT_W-1:0]  own_flit;
   logic               own_vld;
   logic [NDIR-1:0]    route_oh, permit, halt_vec;
   logic               fwd, last, stall_halt;

   assign own_flit = in_flit[owner*FLIT_W +: FLIT_W];
   assign own_vld  = in_vld[owner];

   xy_route #(.COORD_W(COORD_W), .MY_X(MY_X), .MY_Y(MY_Y)) u_route (
      .dst_xy (own_flit[FLIT_W-1 -: 2*COORD_W]),
      .dir_oh (route_oh)
   );

   for (genvar o = 0; o < NDIR; o++) begin : g_out
      link_st_e st;
      assign st          = link_st_e'(ds_state[2*o +: 2]);
      assign halt_vec[o] = (st == LNK_HALT) || (st == LNK_RSV);
      assign permit[o]   = (st == LNK_GO) || ((st == LNK_ONE) && !sent_used[o]);
      assign out_flit[o*FLIT_W +: FLIT_W] = out_vld[o] ? own_flit : '0;

      always_ff @(posedge clk) begin
         if (!rst_n)              sent_used[o] <= 1'b0;
         else if (st != LNK_ONE)  sent_used[o] <= 1'b0;
         else if (out_vld[o])     sent_used[o] <= 1'b1;
      end

      // R8
      halt_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
         out_vld[o] |-> !halt_vec[o]);
      // R9
      one_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (out_vld[o] && st == LNK_ONE) |=> !(out_vld[o] && st == LNK_ONE));
   end

   assign fwd        = busy && own_vld && |(route_oh & permit);
   assign stall_halt = busy && own_vld && |(route_oh & halt_vec);
   assign last       = (cnt == CNT_W'(PKT_FLITS - 1));
   assign out_vld    = fwd ? route_oh : '0;
   assign in_pop     = fwd ? (NDIR'(1) << owner) : '0;

   logic          hi_any, lo_any;
   logic [IW-1:0] hi_idx, lo_idx;

   rr_pick #(.N(NDIR)) u_pick_hi (
      .req (in_vld & ~lowp), .ptr (rr_ptr), .any (hi_any), .idx (hi_idx));
   rr_pick #(.N(NDIR)) u_pick_lo (
      .req (in_vld & lowp),  .ptr (rr_ptr), .any (lo_any), .idx (lo_idx));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         owner  <= '0;
         rr_ptr <= '0;
         cnt    <= '0;
         lowp   <= '0;
      end else begin
         if (!busy) begin
            if (hi_any) begin
               busy  <= 1'b1;
               owner <= hi_idx;
               cnt   <= '0;
            end else if (lo_any) begin
               busy         <= 1'b1;
               owner        <= lo_idx;
               cnt          <= '0;
               lowp[lo_idx] <= 1'b0;
            end
         end else if (fwd) begin
            if (last) begin
               busy   <= 1'b0;
               rr_ptr <= (owner == IW'(NDIR - 1)) ? '0 : owner + 1'b1;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
         if (stall_halt) lowp[owner] <= 1'b1;
      end
   end

   // R5
   single_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(in_pop) && ($countones(out_vld) == $countones(in_pop)));
   // R6
   grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !(fwd && last)) |=> (busy && $stable(owner)));
   // R2
   east_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld[D_E] |-> (out_flit[D_E*FLIT_W + FLIT_W - 1 -: COORD_W] > COORD_W'(MY_X)));
   // R4
   local_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld[D_L] |-> (out_flit[D_L*FLIT_W + FLIT_W - 1 -: 2*COORD_W] ==
                        {COORD_W'(MY_X), COORD_W'(MY_Y)}));
   // R1
   idle_reset_chk: assert property (@(posedge clk)
      !rst_n |=> (out_vld == '0));
endmodule

// File: tb/sim_mesh_xy_switch.sv
module sim_mesh_xy_switch;
   localparam int FW = 20;
   localparam int NP = 5;
   localparam int PF = 4;

   logic            clk = 1'b0;
   logic            rst_n;
   logic [NP-1:0]   in_vld;
   logic [NP*FW-1:0] in_flit;
   logic [2*NP-1:0] ds;
   logic [NP-1:0]   in_pop, out_vld;
   logic [NP*FW-1:0] out_flit;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   always #2.5 clk = ~clk;

   mesh_xy_switch #(.FLIT_W(FW), .COORD_W(3), .PKT_FLITS(PF), .MY_X(3), .MY_Y(3)) u0 (
      .clk (clk), .rst_n (rst_n), .in_vld (in_vld), .in_flit (in_flit),
      .ds_state (ds), .in_pop (in_pop), .out_vld (out_vld), .out_flit (out_flit));

   function automatic logic [FW-1:0] mk(input int dx, input int dy, input int pay);
      return {3'(dx), 3'(dy), 3'd1, 3'd2, 8'(pay)};
   endfunction

   task automatic chk(input bit ok, input string req, input string msg);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: %s", req, msg);
      end
   endtask

   task automatic chk_idle(input string req);
      chk(out_vld == '0 && in_pop == '0, req,
          $sformatf("out_vld=%b in_pop=%b exp 0/0", out_vld, in_pop));
   endtask

   task automatic chk_fwd(input int src, input int dir, input logic [FW-1:0] f, input string req);
      logic [NP*FW-1:0] ef;
      ef = '0;
      ef[dir*FW +: FW] = f;
      chk(out_vld == NP'(1) << dir, req, $sformatf("out_vld=%b exp=%b", out_vld, NP'(1) << dir));
      chk(in_pop == NP'(1) << src, "R5", $sformatf("in_pop=%b exp=%b", in_pop, NP'(1) << src));
      chk(out_flit == ef, "R5", $sformatf("out_flit=%h exp=%h", out_flit, ef));
   endtask

   // single packet from src; checks arbitration cycle and every flit
   task automatic send_pkt(input int src, input logic [FW-1:0] f, input int dir, input string req);
      @(negedge clk);
      in_vld[src] = 1'b1;
      in_flit[src*FW +: FW] = f;
      #1 chk_idle("R6");
      for (int k = 0; k < PF; k++) begin
         @(negedge clk); #1 chk_fwd(src, dir, f, req);
      end
      @(negedge clk);
      in_vld[src] = 1'b0;
   endtask

   // several local-bound requesters; expected service order given
   task automatic serve_seq(input logic [NP-1:0] mask, input int e0, input int e1, input int e2,
                            input int n, input string req);
      int ord[3];
      ord[0] = e0; ord[1] = e1; ord[2] = e2;
      @(negedge clk);
      for (int i = 0; i < NP; i++)
         if (mask[i]) in_flit[i*FW +: FW] = mk(3, 3, 8'h40 + i);
      in_vld = mask;
      for (int p = 0; p < n; p++) begin
         #1 chk_idle("R6");
         for (int k = 0; k < PF; k++) begin
            @(negedge clk); #1 chk_fwd(ord[p], 4, mk(3, 3, 8'h40 + ord[p]), req);
         end
         @(negedge clk);
         in_vld[ord[p]] = 1'b0;
      end
      in_vld = '0;
   endtask

   task automatic t_reset;
      rst_n = 1'b0; in_vld = 5'b11111; ds = '0;
      in_flit = {5{mk(5, 5, 8'h11)}};
      repeat (3) @(negedge clk);
      #1 chk(out_vld == '0 && in_pop == '0 && out_flit == '0, "R1",
             $sformatf("out_vld=%b in_pop=%b during reset exp 0", out_vld, in_pop));
      in_vld = '0;
      @(negedge clk); rst_n = 1'b1;
      #1 chk(out_vld == '0 && in_pop == '0 && out_flit == '0, "R1",
             $sformatf("out_vld=%b in_pop=%b after reset exp 0", out_vld, in_pop));
   endtask

   task automatic t_route;
      send_pkt(3, mk(5, 1, 8'hA1), 1, "R2");   // X larger, Y smaller: east
      send_pkt(0, mk(1, 5, 8'hA2), 3, "R2");   // X smaller, Y larger: west
      send_pkt(1, mk(3, 5, 8'hA3), 0, "R3");   // north
      send_pkt(2, mk(3, 0, 8'hA4), 2, "R3");   // south
      send_pkt(4, mk(3, 3, 8'hA5), 4, "R4");   // local
   endtask

   task automatic t_rr;
      // pointer at 0 after input 4 served; 1 then 3 then 4
      serve_seq(5'b11010, 1, 3, 4, 3, "R7");
      // pointer at 0 after 4: 0 then 2
      serve_seq(5'b00101, 0, 2, 0, 2, "R7");
   endtask

   task automatic t_halt;
      logic [FW-1:0] f;
      f = mk(6, 3, 8'hB3);
      @(negedge clk);
      ds[2*1 +: 2] = 2'd2;
      in_vld[3] = 1'b1; in_flit[3*FW +: FW] = f;
      #1 chk_idle("R6");
      for (int k = 0; k < 3; k++) begin
         @(negedge clk); #1 chk_idle("R8");
      end
      @(negedge clk); ds[2*1 +: 2] = 2'd3;
      #1 chk_idle("R8");
      @(negedge clk); ds[2*1 +: 2] = 2'd0;
      #1 chk_fwd(3, 1, f, "R8");
      for (int k = 1; k < PF; k++) begin
         @(negedge clk); #1 chk_fwd(3, 1, f, "R8");
      end
      @(negedge clk); in_vld[3] = 1'b0;
   endtask

   task automatic t_demote;
      send_pkt(1, mk(3, 3, 8'hC1), 4, "R10");          // pointer -> 2
      serve_seq(5'b11000, 4, 3, 0, 2, "R10");          // demoted 3 loses to 4
      send_pkt(1, mk(3, 3, 8'hC2), 4, "R10");          // pointer -> 2
      serve_seq(5'b11000, 3, 4, 0, 2, "R10");          // rank restored
   endtask

   task automatic t_one_slot;
      logic [FW-1:0] f;
      f = mk(3, 1, 8'hD0);
      @(negedge clk);
      ds[2*2 +: 2] = 2'd1;
      in_vld[0] = 1'b1; in_flit[0 +: FW] = f;
      #1 chk_idle("R6");
      @(negedge clk); #1 chk_fwd(0, 2, f, "R9");
      for (int k = 0; k < 2; k++) begin
         @(negedge clk); #1 chk_idle("R9");
      end
      @(negedge clk); ds[2*2 +: 2] = 2'd0;
      for (int k = 1; k < PF; k++) begin
         #1 chk_fwd(0, 2, f, "R9");
         @(negedge clk);
      end
      in_vld[0] = 1'b0;
   endtask

   task automatic t_bubble;
      logic [FW-1:0] f2, f4;
      f2 = mk(3, 3, 8'hE2);
      f4 = mk(3, 3, 8'hE4);
      @(negedge clk);
      in_vld[2] = 1'b1; in_flit[2*FW +: FW] = f2; in_flit[4*FW +: FW] = f4;
      #1 chk_idle("R6");
      @(negedge clk); #1 chk_fwd(2, 4, f2, "R11");
      @(negedge clk);
      in_vld[2] = 1'b0; in_vld[4] = 1'b1;
      #1 chk_idle("R11");
      @(negedge clk); #1 chk_idle("R11");
      @(negedge clk); in_vld[2] = 1'b1;
      for (int k = 1; k < PF; k++) begin
         #1 chk_fwd(2, 4, f2, "R11");
         @(negedge clk);
      end
      in_vld[2] = 1'b0;
      #1 chk_idle("R6");
      for (int k = 0; k < PF; k++) begin
         @(negedge clk); #1 chk_fwd(4, 4, f4, "R7");
      end
      @(negedge clk); in_vld[4] = 1'b0;
   endtask

   initial begin
      t_reset();
      t_route();
      t_rr();
      t_halt();
      t_demote();
      t_one_slot();
      t_bubble();
      repeat (2) @(negedge clk);
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #1000000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: run hung, actual=timeout expected=completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule